// File: doc/BRIEF.md
# Neighborhood-blend watermark insertion datapath

This block computes one watermarked pixel from a 2x2 window of an 8-bit grey image. It receives the centre pixel at (i,j) and three neighbours: the one to its right (i,j+1), the one below (i+1,j) and the one diagonally below-right (i+1,j+1). It also receives two scaling constants and a ternary watermark symbol.

For symbols 1 and 2 the block forms a neighbourhood average from the three neighbours. It weights that average with the complement of the first constant and weights the centre pixel with one of the two constants. The two weighted terms are then added (symbol 1) or subtracted (symbol 2). For symbol 0 the centre pixel passes through unchanged.

A controller walks the image and presents one window per `in_valid` pulse. The result appears one clock later, qualified by `out_valid`.

Top module: `wm_blend_insert`

## Requirements
- R1: While `rst_n` is low and after its release until the first accepted window, `out_valid` is 0 and `out_pix` is 0.
- R2: A window accepted with `in_valid` high at a rising edge gives `out_valid` high for exactly the following cycle. Back-to-back windows give back-to-back results, and `out_valid` is low after any cycle with `in_valid` low.
- R3: The neighbourhood average is nb = ((`pix_dn` + `pix_dr`) >> 1 + `pix_rt`) >> 1. Every sum keeps its carry bit, and each halving drops the LSB.
- R4: The weighted terms are the upper bytes of 8x8 unsigned products: nbt = (nb * (255 − `alpha_p`)) >> 8 and ct = (`pix_c` * k) >> 8. Here k is `alpha_p` for symbol 1 and `alpha_n` for symbol 2.
- R5: With `sym` = 2'd1 the result is nbt + ct, limited to 255. This sum never exceeds 254 for any input.
- R6: With `sym` = 2'd2 the result is nbt − ct, clamped to 0 when ct > nbt.
- R7: With `sym` = 2'd0 or 2'd3 the result is `pix_c`. The neighbours and both constants have no effect on it.
- R8: `out_pix` holds its last value in every cycle that follows a cycle with `in_valid` low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and symbol are valid this cycle |
| pix_c | input | 8 | Centre pixel (i,j) |
| pix_rt | input | 8 | Right neighbour (i,j+1) |
| pix_dn | input | 8 | Lower neighbour (i+1,j) |
| pix_dr | input | 8 | Lower-right neighbour (i+1,j+1) |
| alpha_p | input | 8 | Positive constant, units of 1/256 |
| alpha_n | input | 8 | Magnitude of the negative constant, units of 1/256 |
| sym | input | 2 | Watermark symbol: 0 pass, 1 add, 2 subtract, 3 pass |
| out_valid | output | 1 | Result valid (done) |
| out_pix | output | 8 | Watermarked pixel |

## Verification
There is a single pipeline register, so any fault in the average, the products, the symbol decode or the clamp shows up on `out_pix` in the cycle right after the window is accepted. Two window choices target the halving stages. In one, the lower pair sums to 256, so a lost carry turns an expected 63 into 0. The subtract cases include an underflow that must read 0 rather than a wrapped value. A fault in the valid path or in the hold enable shows up on `out_valid`, or as a changed `out_pix` during idle cycles while the inputs are scrambled.

// File: rtl/wm_blend_insert.sv
module wm_blend_insert #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] pix_c,
  input  logic [W-1:0] pix_rt,
  input  logic [W-1:0] pix_dn,
  input  logic [W-1:0] pix_dr,
  input  logic [W-1:0] alpha_p,
  input  logic [W-1:0] alpha_n,
  input  logic [1:0]   sym,
  output logic         out_valid,
  output logic [W-1:0] out_pix
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] PIX_MAX = {W{1'b1}};

  logic [W:0]    pair_sum, mid_sum;
  logic [W-1:0]  nb_avg, nb_wgt, c_coef, nb_term, c_term, mix;
  logic [PW-1:0] prod_nb, prod_c;
  logic [W:0]    add_res, sub_res;

  assign pair_sum = {1'b0, pix_dn} + {1'b0, pix_dr};
  assign mid_sum  = {1'b0, pair_sum[W:1]} + {1'b0, pix_rt};
  assign nb_avg   = mid_sum[W:1];

  assign nb_wgt  = ~alpha_p;
  assign c_coef  = (sym == 2'd2) ? alpha_n : alpha_p;
  assign prod_nb = {{W{1'b0}}, nb_avg} * {{W{1'b0}}, nb_wgt};
  assign prod_c  = {{W{1'b0}}, pix_c} * {{W{1'b0}}, c_coef};
  assign nb_term = prod_nb[PW-1:W];
  assign c_term  = prod_c[PW-1:W];

  assign add_res = {1'b0, nb_term} + {1'b0, c_term};
  assign sub_res = {1'b0, nb_term} - {1'b0, c_term};

  always_comb begin
    case (sym)
      2'd1:    mix = add_res[W] ? PIX_MAX : add_res[W-1:0];
      2'd2:    mix = sub_res[W] ? '0 : sub_res[W-1:0];
      default: mix = pix_c;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= mix;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pix));
  // R7
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (sym == 2'd0 || sym == 2'd3)) |=> out_pix == $past(pix_c));
  // R6
  sub_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sym == 2'd2) |=> out_pix <= $past(nb_avg));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sym == 2'd1) |=> (out_pix >= $past(nb_term) && out_pix != PIX_MAX));
endmodule

// File: tb/tb_wm_blend_insert.sv
module tb_wm_blend_insert;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] pix_c = 0, pix_rt = 0, pix_dn = 0, pix_dr = 0, alpha_p = 0, alpha_n = 0;
  logic [1:0] sym = 0;
  logic out_valid;
  logic [7:0] out_pix;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wm_blend_insert dut (.clk, .rst_n, .in_valid, .pix_c, .pix_rt, .pix_dn, .pix_dr,
                       .alpha_p, .alpha_n, .sym, .out_valid, .out_pix);

  // {c, rt, dn, dr, alpha_p, alpha_n, sym, expected}
  localparam int NV = 10;
  localparam logic [57:0] VEC [NV] = '{
    {8'd100, 8'd50,  8'd60,  8'd70,  8'd128, 8'd0,   2'd1, 8'd78},
    {8'd100, 8'd50,  8'd60,  8'd70,  8'd128, 8'd64,  2'd2, 8'd3},
    {8'd100, 8'd50,  8'd60,  8'd70,  8'd128, 8'd64,  2'd0, 8'd100},
    {8'd100, 8'd9,   8'd200, 8'd33,  8'd7,   8'd250, 2'd3, 8'd100},
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd0,   8'd0,   2'd1, 8'd254},
    {8'd255, 8'd0,   8'd0,   8'd0,   8'd0,   8'd255, 2'd2, 8'd0},
    {8'd10,  8'd200, 8'd200, 8'd200, 8'd0,   8'd255, 2'd2, 8'd190},
    {8'd0,   8'd0,   8'd255, 8'd1,   8'd0,   8'd0,   2'd1, 8'd63},
    {8'd200, 8'd0,   8'd0,   8'd0,   8'd255, 8'd0,   2'd1, 8'd199},
    {8'd37,  8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 2'd0, 8'd37}
  };
  localparam string TAG [NV] = '{"R4 R5", "R4 R6", "R7", "R7", "R5",
                                 "R6", "R3 R6", "R3", "R4 R5", "R7"};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", {7'd0, out_valid}, 8'd0);
    chk("R1 pix", out_pix, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", {7'd0, out_valid}, 8'd0);
    chk("R1 pix after release", out_pix, 8'd0);

    // streaming back-to-back windows (R2)
    for (int k = 0; k <= NV; k++) begin
      if (k > 0) begin
        chk("R2 valid", {7'd0, out_valid}, 8'd1);
        chk(TAG[k-1], out_pix, VEC[k-1][7:0]);
      end
      if (k < NV) begin
        {pix_c, pix_rt, pix_dn, pix_dr, alpha_p, alpha_n, sym} = VEC[k][57:8];
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end

    // idle: output holds while inputs change (R8, R2)
    chk("R2 valid drop", {7'd0, out_valid}, 8'd0);
    chk("R8 hold", out_pix, 8'd37);
    pix_c = 8'd1; pix_rt = 8'd2; sym = 2'd1; alpha_p = 8'd200;
    @(negedge clk);
    chk("R8 hold scrambled", out_pix, 8'd37);
    chk("R2 valid idle", {7'd0, out_valid}, 8'd0);

    // single pulse, one cycle of valid (R2)
    {pix_c, pix_rt, pix_dn, pix_dr, alpha_p, alpha_n, sym} =
      {8'd100, 8'd50, 8'd60, 8'd70, 8'd128, 8'd0, 2'd1};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 pulse valid", {7'd0, out_valid}, 8'd1);
    chk("R5 pulse value", out_pix, 8'd78);
    @(negedge clk);
    chk("R2 pulse single", {7'd0, out_valid}, 8'd0);

    // reset mid-stream clears (R1)
    in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears valid", {7'd0, out_valid}, 8'd0);
    chk("R1 reset clears pix", out_pix, 8'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule